// File: doc/BRIEF.md
# DDR2 Self-Refresh Exit Sequencer

This block brings a DDR2 memory device out of self refresh and back into it later. Out of reset it assumes the device is in self refresh, so it holds the clock enable low and keeps the command bus deselected. A request to leave is held until the clock is reported stable. At that point the block raises the clock enable and starts two separate countdowns. The shorter one gates ordinary commands. The longer one keeps on-die termination off.

While the command window is closed, the block drives Deselect on the bus and keeps its ready flag low. Once the window has run out, the command bus and the termination request from the rest of the controller pass straight through. The block watches that traffic for an auto refresh.

Re-entry into self refresh is allowed only after two things have happened since the last exit: one auto refresh has been issued, and its refresh cycle time has run out. A re-entry request that arrives earlier is held until both are true. The entry itself takes one cycle, with the clock enable low and the refresh encoding on the bus.

Top module: `ddr2_sr_exit_seq`

## Requirements
- R1: After reset, cke_o is 0, the bus carries Deselect (cs_n, ras_n, cas_n, we_n = 1,1,1,1), odt_o is 0 and ready_o is 0.
- R2: While in self refresh, an exit request is remembered. cke_o rises on the cycle after a clock edge at which an exit is pending or requested and clk_stable_i is 1, and at no other time.
- R3: For T_XSNR cycles after cke_o rises, the bus carries Deselect and ready_o is 0, whatever ctl_cmd_i holds.
- R4: ready_o rises exactly T_XSNR cycles after cke_o rises. While ready_o is 1, the bus outputs equal ctl_cmd_i, ordered {cs_n, ras_n, cas_n, we_n} from bit 3 down to bit 0.
- R5: odt_o stays 0 for T_XSRD cycles after cke_o rises. After that, while ready_o is 1, it equals ctl_odt_i.
- R6: Once risen, cke_o stays 1 until the self-refresh entry cycle.
- R7: A command passed through with the auto refresh encoding (ctl_cmd_i = 4'b0001) marks the refresh as done and starts a T_RFC countdown. A re-entry request made before both the refresh and the countdown are complete is held pending.
- R8: Re-entry happens in the first cycle in which the device is ready, a re-entry request is pending or present, a refresh has been done and the T_RFC countdown is at zero. In that cycle cke_o is 0, the bus is 4'b0001 and ready_o is 0. From the next cycle on, cke_o is 0 and the bus carries Deselect.
- R9: Each exit clears the refresh-done mark, so every later re-entry needs a new auto refresh.
- R10: A re-entry request made while in self refresh is ignored. An exit request made outside self refresh is ignored and is not remembered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_stable_i | input | 1 | Clock to the device is stable |
| exit_req_i | input | 1 | Request to leave self refresh |
| reenter_req_i | input | 1 | Request to enter self refresh again |
| ctl_cmd_i | input | 4 | Controller command {cs_n, ras_n, cas_n, we_n} |
| ctl_odt_i | input | 1 | Controller termination request |
| cke_o | output | 1 | Device clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| odt_o | output | 1 | On-die termination enable |
| ready_o | output | 1 | Bus accepts controller commands |

## Verification
The bench holds an exit request across cycles in which the clock is not yet stable. A design that drops the pending request never leaves self refresh, and one that ignores the stability input raises the clock enable too early. It issues the auto refresh while termination is still forced off and counts the cycles to the exact edges where ready and termination open, so an off-by-one in either countdown shows up as a mismatch on the bus or on odt_o. A second exit with no new refresh catches a design that keeps the refresh mark across exits, because such a design would re-enter as soon as it became ready. Requests sent to the wrong state catch a design that latches them anyway, because the stale request later causes a spurious re-entry or exit.

// File: rtl/ddr2_sr_pkg.sv
package ddr2_sr_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } ddr_cmd_t;

    localparam ddr_cmd_t CMD_DESEL   = 4'b1111;
    localparam ddr_cmd_t CMD_REFRESH = 4'b0001;

    typedef enum logic {
        ST_SELF   = 1'b0,
        ST_ACTIVE = 1'b1
    } seq_state_t;

    function automatic logic is_refresh(input ddr_cmd_t c);
        return c == CMD_REFRESH;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sr_countdown.sv
module sr_countdown #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          at_zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/sr_bus_drive.sv
module sr_bus_drive
    import ddr2_sr_pkg::*;
(
    input  logic     active,
    input  logic     enter,
    input  logic     pass,
    input  logic     odt_open,
    input  ddr_cmd_t ctl_cmd,
    input  logic     ctl_odt,
    output logic     cke,
    output ddr_cmd_t bus_cmd,
    output logic     odt
);
    always_comb begin
        cke     = active && !enter;
        bus_cmd = CMD_DESEL;
        if (enter) begin
            bus_cmd = CMD_REFRESH;
        end else if (pass) begin
            bus_cmd = ctl_cmd;
        end
        odt = pass && odt_open && ctl_odt;
    end
endmodule

// File: rtl/ddr2_sr_exit_seq.sv
module ddr2_sr_exit_seq
    import ddr2_sr_pkg::*;
#(
    parameter int T_XSNR = 70,
    parameter int T_XSRD = 200,
    parameter int T_RFC  = 52
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_stable_i,
    input  logic       exit_req_i,
    input  logic       reenter_req_i,
    input  logic [3:0] ctl_cmd_i,
    input  logic       ctl_odt_i,
    output logic       cke_o,
    output logic       cs_n_o,
    output logic       ras_n_o,
    output logic       cas_n_o,
    output logic       we_n_o,
    output logic       odt_o,
    output logic       ready_o
);
    localparam int CW = $clog2(max3(T_XSNR, T_XSRD, T_RFC) + 1);

    seq_state_t st_q;
    logic       exit_pend_q, reenter_pend_q, refreshed_q;
    logic       xsnr_zero, xsrd_zero, rfc_zero;
    logic       in_self, do_exit, cmd_open, do_enter, ref_issued;
    ddr_cmd_t   ctl_cmd, bus_cmd;

    assign ctl_cmd    = ctl_cmd_i;
    assign in_self    = (st_q == ST_SELF);
    assign do_exit    = in_self && (exit_pend_q || exit_req_i) && clk_stable_i;
    assign cmd_open   = !in_self && xsnr_zero;
    assign do_enter   = cmd_open && (reenter_pend_q || reenter_req_i)
                        && refreshed_q && rfc_zero;
    assign ready_o    = cmd_open && !do_enter;
    assign ref_issued = ready_o && is_refresh(ctl_cmd);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= ST_SELF;
            exit_pend_q    <= 1'b0;
            reenter_pend_q <= 1'b0;
            refreshed_q    <= 1'b0;
        end else begin
            if (do_exit) begin
                st_q <= ST_ACTIVE;
            end else if (do_enter) begin
                st_q <= ST_SELF;
            end

            if (do_exit) begin
                exit_pend_q <= 1'b0;
            end else if (in_self && exit_req_i) begin
                exit_pend_q <= 1'b1;
            end

            if (in_self || do_enter) begin
                reenter_pend_q <= 1'b0;
            end else if (reenter_req_i) begin
                reenter_pend_q <= 1'b1;
            end

            if (do_exit) begin
                refreshed_q <= 1'b0;
            end else if (ref_issued) begin
                refreshed_q <= 1'b1;
            end
        end
    end

    sr_countdown #(.CW(CW)) u_xsnr_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (do_exit),
        .load_val (CW'(T_XSNR)),
        .at_zero  (xsnr_zero)
    );

    sr_countdown #(.CW(CW)) u_xsrd_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (do_exit),
        .load_val (CW'(T_XSRD)),
        .at_zero  (xsrd_zero)
    );

    sr_countdown #(.CW(CW)) u_rfc_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (ref_issued),
        .load_val (CW'(T_RFC)),
        .at_zero  (rfc_zero)
    );

    sr_bus_drive u_bus (
        .active   (!in_self),
        .enter    (do_enter),
        .pass     (ready_o),
        .odt_open (xsrd_zero),
        .ctl_cmd  (ctl_cmd),
        .ctl_odt  (ctl_odt_i),
        .cke      (cke_o),
        .bus_cmd  (bus_cmd),
        .odt      (odt_o)
    );

    assign cs_n_o  = bus_cmd.cs_n;
    assign ras_n_o = bus_cmd.ras_n;
    assign cas_n_o = bus_cmd.cas_n;
    assign we_n_o  = bus_cmd.we_n;
endmodule

// File: rtl/ddr2_sr_exit_chk.sv
module ddr2_sr_exit_chk #(
    parameter int T_XSNR = 70,
    parameter int T_XSRD = 200
) (
    input logic clk,
    input logic rst,
    input logic clk_stable_i,
    input logic cke_o,
    input logic cs_n_o,
    input logic ras_n_o,
    input logic cas_n_o,
    input logic we_n_o,
    input logic odt_o,
    input logic ready_o
);
    localparam int LIM = (T_XSNR > T_XSRD) ? T_XSNR : T_XSRD;
    localparam int HW  = $clog2(LIM + 1) + 1;

    logic [HW-1:0] hi_cnt;
    logic [3:0]    bus;

    assign bus = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

    always_ff @(posedge clk) begin
        if (rst || !cke_o) begin
            hi_cnt <= '0;
        end else if (hi_cnt <= HW'(LIM)) begin
            hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R2
    cke_rise_needs_stable_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_o) |-> $past(clk_stable_i));

    // R3
    quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (cke_o && !ready_o) |-> (bus == 4'b1111));

    // R4
    ready_after_xsnr_chk: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (hi_cnt >= HW'(T_XSNR)));

    // R5
    odt_after_xsrd_chk: assert property (@(posedge clk) disable iff (rst)
        odt_o |-> (cke_o && hi_cnt >= HW'(T_XSRD)));

    // R8
    cke_fall_with_refresh_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke_o && $past(cke_o)) |-> (bus == 4'b0001 && !ready_o));

    // R1
    self_bus_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!cke_o && !$past(cke_o)) |-> (bus == 4'b1111 && !odt_o && !ready_o));
endmodule

bind ddr2_sr_exit_seq ddr2_sr_exit_chk #(
    .T_XSNR (T_XSNR),
    .T_XSRD (T_XSRD)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clk_stable_i (clk_stable_i),
    .cke_o        (cke_o),
    .cs_n_o       (cs_n_o),
    .ras_n_o      (ras_n_o),
    .cas_n_o      (cas_n_o),
    .we_n_o       (we_n_o),
    .odt_o        (odt_o),
    .ready_o      (ready_o)
);

// File: tb/ddr2_sr_exit_seq_bench.sv
module ddr2_sr_exit_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int XSNR = 4;
    localparam int XSRD = 7;
    localparam int RFC  = 3;
    localparam int NV   = 29;

    // inputs {exit, stable, reenter, cmd[3:0], odt} , expected {cke, bus[3:0], odt, ready}
    localparam logic [14:0] VEC [NV] = '{
        15'b1_0_0_0011_1_0_1111_0_0,
        15'b0_0_0_0011_1_0_1111_0_0,
        15'b0_1_0_0011_1_0_1111_0_0,
        15'b0_1_0_0011_1_1_1111_0_0,
        15'b0_1_1_0011_1_1_1111_0_0,
        15'b0_1_0_0011_1_1_1111_0_0,
        15'b0_1_0_0011_1_1_1111_0_0,
        15'b0_1_0_0011_1_1_0011_0_1,
        15'b0_1_0_0001_1_1_0001_0_1,
        15'b0_1_0_0011_1_1_0011_0_1,
        15'b0_1_0_0011_1_1_0011_1_1,
        15'b0_1_0_0011_1_1_0011_1_1,
        15'b0_1_0_0011_1_0_0001_0_0,
        15'b0_1_0_0011_1_0_1111_0_0,
        15'b1_1_0_0011_1_0_1111_0_0,
        15'b0_1_0_0011_1_1_1111_0_0,
        15'b0_1_0_0011_1_1_1111_0_0,
        15'b0_1_0_0011_1_1_1111_0_0,
        15'b0_1_0_0011_1_1_1111_0_0,
        15'b0_1_1_0011_1_1_0011_0_1,
        15'b1_1_0_0011_1_1_0011_0_1,
        15'b0_1_0_0011_1_1_0011_0_1,
        15'b0_1_0_0011_1_1_0011_1_1,
        15'b0_1_0_0001_1_1_0001_1_1,
        15'b0_1_0_0011_1_1_0011_1_1,
        15'b0_1_0_0011_1_1_0011_1_1,
        15'b0_1_0_0011_1_1_0011_1_1,
        15'b0_1_0_0011_1_0_0001_0_0,
        15'b0_1_0_0011_1_0_1111_0_0
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clk_stable_i = 1'b0;
    logic       exit_req_i = 1'b0;
    logic       reenter_req_i = 1'b0;
    logic [3:0] ctl_cmd_i = 4'b1111;
    logic       ctl_odt_i = 1'b0;
    logic       cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, odt_o, ready_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ddr2_sr_exit_seq #(.T_XSNR(XSNR), .T_XSRD(XSRD), .T_RFC(RFC)) u_ddr2_sr_exit_seq (
        .clk           (clk),
        .rst           (rst),
        .clk_stable_i  (clk_stable_i),
        .exit_req_i    (exit_req_i),
        .reenter_req_i (reenter_req_i),
        .ctl_cmd_i     (ctl_cmd_i),
        .ctl_odt_i     (ctl_odt_i),
        .cke_o         (cke_o),
        .cs_n_o        (cs_n_o),
        .ras_n_o       (ras_n_o),
        .cas_n_o       (cas_n_o),
        .we_n_o        (we_n_o),
        .odt_o         (odt_o),
        .ready_o       (ready_o)
    );

    function automatic string row_req(input int i);
        if (i <= 2) return "R2";
        if (i <= 6) return "R3";
        if (i == 7) return "R4";
        if (i <= 11) return "R5";
        if (i <= 14) return "R8";
        if (i <= 18) return "R3";
        if (i <= 21) return "R9";
        if (i == 22) return "R5";
        if (i <= 26) return "R7";
        return "R8";
    endfunction

    task automatic check_out(input string req, input logic [6:0] exp);
        logic [6:0] act;
        act = {cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, odt_o, ready_o};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {cke,bus,odt,ready} actual=%b expected=%b at t=%0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic drive(input logic ex, input logic st, input logic re,
                         input logic [3:0] cmd, input logic od);
        exit_req_i    = ex;
        clk_stable_i  = st;
        reenter_req_i = re;
        ctl_cmd_i     = cmd;
        ctl_odt_i     = od;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected=under 5000", cycles);
            finish_run();
        end
    end

    initial begin
        int waited;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b0, 1'b0, 4'b0011, 1'b1);
        #1;
        // R1: state right after reset
        check_out("R1", 7'b0_1111_0_0);

        // table walk: each row is one cycle, sampled before the next edge
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11:8], VEC[i][7]);
            #1;
            check_out(row_req(i), VEC[i][6:0]);
        end

        // directed: reset again, re-entry request while in self refresh is dropped (R10)
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(1'b0, 1'b1, 1'b1, 4'b0011, 1'b0);
        #1;
        check_out("R1", 7'b0_1111_0_0);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 4'b0011, 1'b0);
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 4'b0011, 1'b0);
        waited = 0;
        #1;
        while (!ready_o && waited < 20) begin
            // R6: clock enable held high through the exit interval
            check_out("R6", 7'b1_1111_0_0);
            @(negedge clk);
            waited++;
            #1;
        end
        checks++;
        if (waited != XSNR) begin
            failures++;
            $display("FAIL R4: ready delay actual=%0d expected=%0d", waited, XSNR);
        end
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b0, 4'b0001, 1'b0);
        for (int k = 0; k < RFC + 2; k++) begin
            @(negedge clk);
            drive(1'b0, 1'b1, 1'b0, 4'b0011, 1'b0);
            #1;
            // R10: no stale re-entry from the request made in self refresh
            check_out("R10", 7'b1_0011_0_1);
        end
        // exit request while active must not be remembered (R10)
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 4'b0011, 1'b0);
        #1;
        check_out("R10", 7'b1_0011_0_1);
        @(negedge clk);
        drive(1'b0, 1'b1, 1'b1, 4'b0011, 1'b0);
        #1;
        check_out("R8", 7'b0_0001_0_0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            drive(1'b0, 1'b1, 1'b0, 4'b0011, 1'b0);
            #1;
            check_out("R10", 7'b0_1111_0_0);
        end
        finish_run();
    end
endmodule